// File: doc/BRIEF.md
# Switchable Clock Divider Channel

This block is one output channel of a clock controller. It takes two unrelated parent clocks, chooses one of them, divides the chosen clock by an integer between 1 and 256, and drives the result out through an enable gate. Software programs the channel through a small synchronous register port: one bit selects the parent, one bit enables the channel, and an 8-bit field holds the divide value.

Writing the divide field does not change the output right away. The new value sits in a staging register. It moves into the running divider only when software raises a separate load bit and then clears it. The transfer needs the channel clock to be running. A load issued while the channel is gated is lost, so after enabling the channel software issues the load again. The divider switches to the new ratio only at the end of an output period. The parent switch stops the old clock low before it releases the new one.

Top module: `clkchan_muxdiv`

## Requirements
- R1: After reset the select bit, the enable bit, the staged divide field and the load bit all read 0, and `clk_out` shows no rising edge.
- R2: Register layout (byte addresses): the select bit is bit 3 at 0x80, the enable bit is bit 3 at 0x8C, the divide field is bits 23:16 at 0x94, and the load bit is bit 1 at 0x70. All other bits of these words read 0. Any other address reads 0. Read data appears on `bus_rdata` one `clk` cycle after `bus_rd`.
- R3: A select value of 0 routes `clk_src0` and a value of 1 routes `clk_src1`.
- R4: Once a divide value d is active, the period of `clk_out` is (d+1) times the period of the selected parent, for d from 0 to 255.
- R5: Reading the divide register returns the staged value, even before that value is loaded.
- R6: A staged divide value has no effect on `clk_out` until the load bit goes from 0 to 1 while the channel runs.
- R7: A load issued while the enable bit is 0 is ignored. A load issued after enabling applies the staged value.
- R8: While the enable bit is 0, `clk_out` shows no rising edge.
- R9: The two parent paths are never enabled together.
- R10: The active divide value changes only on the output clock edge that ends a full divided period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register port clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| clk_src0 | input | 1 | Parent clock 0 |
| clk_src1 | input | 1 | Parent clock 1 |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| clk_out | output | 1 | Divided, gated channel clock |

## Verification
The hardest case to reach is a load that is lost. The load pulse has to arrive while the gate is closed, and the channel must then restart without seeing an edge on the load bit. To get there, the stimulus disables the channel, waits past the enable synchronizer, stages a new value, issues a full load pulse and then re-enables. It measures the output period, which should still show the old ratio. A second load then shows the new ratio. Every ratio check measures the spacing of output edges only after waiting out the old divided period, because the new value lands only at a period boundary.

// File: rtl/clkchan_muxdiv.sv
`timescale 1ns/1ps
module clkchan_muxdiv #(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int SEL_IDX   = 0,
  parameter int SEL_BIT   = 3,
  parameter int EN_BIT    = 3,
  parameter int DIV_IDX   = 0,
  parameter int DIV_OFS   = 16,
  parameter int LOAD_ADDR = 'h70,
  parameter int LOAD_BIT  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_src0,
  input  logic          clk_src1,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          clk_out
);
  localparam logic [AW-1:0] SEL_ADDR = AW'('h80 + 4 * SEL_IDX);
  localparam logic [AW-1:0] EN_ADDR  = AW'('h8C);
  localparam logic [AW-1:0] DIV_ADDR = AW'('h94 + 4 * DIV_IDX);
  localparam logic [AW-1:0] LD_ADDR  = AW'(LOAD_ADDR);

  logic          sel_r, en_r, ld_r;
  logic [DW-1:0] stg;
  logic [31:0]   rd_mux;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_r <= 1'b0;
      en_r  <= 1'b0;
      ld_r  <= 1'b0;
      stg   <= '0;
    end else if (bus_wr) begin
      if (bus_addr == SEL_ADDR) sel_r <= bus_wdata[SEL_BIT];
      if (bus_addr == EN_ADDR)  en_r  <= bus_wdata[EN_BIT];
      if (bus_addr == LD_ADDR)  ld_r  <= bus_wdata[LOAD_BIT];
      if (bus_addr == DIV_ADDR) stg   <= bus_wdata[DIV_OFS +: DW];
    end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == SEL_ADDR) rd_mux[SEL_BIT] = sel_r;
    if (bus_addr == EN_ADDR)  rd_mux[EN_BIT] = en_r;
    if (bus_addr == LD_ADDR)  rd_mux[LOAD_BIT] = ld_r;
    if (bus_addr == DIV_ADDR) rd_mux[DIV_OFS +: DW] = stg;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;

  // parent switch: each side releases only after the other has stopped low
  logic s0a, s0, s1a, s1, mux_clk;

  always_ff @(posedge clk_src0 or negedge rst_n)
    if (!rst_n) s0a <= 1'b0; else s0a <= ~sel_r & ~s1;
  always_ff @(negedge clk_src0 or negedge rst_n)
    if (!rst_n) s0 <= 1'b0; else s0 <= s0a;
  always_ff @(posedge clk_src1 or negedge rst_n)
    if (!rst_n) s1a <= 1'b0; else s1a <= sel_r & ~s0;
  always_ff @(negedge clk_src1 or negedge rst_n)
    if (!rst_n) s1 <= 1'b0; else s1 <= s1a;

  assign mux_clk = (clk_src0 & s0) | (clk_src1 & s1);

  // enable gate ahead of the divider
  logic en_m1, en_m2, en_lat, gclk;

  always_ff @(posedge mux_clk or negedge rst_n)
    if (!rst_n) {en_m2, en_m1} <= 2'b00;
    else        {en_m2, en_m1} <= {en_m1, en_r};

  always_latch
    if (!rst_n)        en_lat = 1'b0;
    else if (!mux_clk) en_lat = en_m2;

  assign gclk = mux_clk & en_lat;

  // divider with load handshake
  logic          l1, l2, l3, ld_rise, pend, npend, dq, ndq;
  logic [DW-1:0] act, cnt, na, nc;
  logic [DW:0]   half;

  always_ff @(posedge gclk or negedge rst_n)
    if (!rst_n) {l3, l2, l1} <= 3'b000;
    else        {l3, l2, l1} <= {l2, l1, ld_r};

  assign ld_rise = l2 & ~l3;

  always_comb begin
    na    = act;
    nc    = cnt + 1'b1;
    npend = pend | ld_rise;
    if (cnt == act) begin
      nc = '0;
      if (npend) begin
        na    = stg;
        npend = 1'b0;
      end
    end
    half = ({1'b0, na} + 2'd2) >> 1;
    ndq  = ({1'b0, nc} < half);
  end

  always_ff @(posedge gclk or negedge rst_n)
    if (!rst_n) begin
      act  <= '0;
      cnt  <= '0;
      pend <= 1'b0;
      dq   <= 1'b0;
    end else begin
      act  <= na;
      cnt  <= nc;
      pend <= npend;
      dq   <= ndq;
    end

  assign clk_out = (act == '0) ? gclk : dq;
endmodule

module clkchan_muxdiv_chk #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int DIV_OFS = 16,
  parameter logic [AW-1:0] DIV_ADDR = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gclk,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [DW-1:0] stg,
  input logic [DW-1:0] act,
  input logic [DW-1:0] cnt,
  input logic          pend,
  input logic          ld_rise,
  input logic          s0,
  input logic          s1
);
  a_r5_staged_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == DIV_ADDR) |=> (stg == $past(bus_wdata[DIV_OFS +: DW])));

  a_r9_one_parent: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({s0, s1}));

  a_r6_hold_without_load: assert property (@(posedge gclk) disable iff (!rst_n)
    (!pend && !ld_rise) |=> $stable(act));

  a_r10_period_end: assert property (@(posedge gclk) disable iff (!rst_n)
    !$stable(act) |-> ($past(cnt) == $past(act)));
endmodule

bind clkchan_muxdiv clkchan_muxdiv_chk #(
  .AW(AW), .DW(DW), .DIV_OFS(DIV_OFS), .DIV_ADDR(DIV_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .gclk(gclk), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .stg(stg), .act(act), .cnt(cnt), .pend(pend),
  .ld_rise(ld_rise), .s0(s0), .s1(s1)
);

// File: tb/clkchan_muxdiv_tb.sv
`timescale 1ns/1ps
module clkchan_muxdiv_tb_top;
  localparam logic [7:0] A_SEL = 8'h80, A_EN = 8'h8C, A_DIV = 8'h94, A_LD = 8'h70;
  localparam int T0 = 6, T1 = 14, NV = 8;
  localparam int V_SEL [NV] = '{0, 0, 0, 1, 1, 0, 0, 1};
  localparam int V_DIV [NV] = '{0, 1, 4, 0, 2, 255, 2, 7};
  localparam int V_PER [NV] = '{6, 12, 30, 14, 42, 1536, 18, 112};

  logic clk = 0, src0 = 0, src1 = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0, clk_out;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int nchk = 0, nfail = 0, edges = 0;
  time t_last = 0, t_prev = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always #3 src0 = ~src0;
  always #7 src1 = ~src1;

  clkchan_muxdiv dut_i (
    .clk(clk), .rst_n(rst_n), .clk_src0(src0), .clk_src1(src1),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_out(clk_out)
  );

  always @(posedge clk_out) begin
    edges++;
    t_prev = t_last;
    t_last = $time;
  end

  task automatic check(input string tag, input longint actv, input longint expv);
    nchk++;
    if (actv != expv) begin
      nfail++;
      $display("FAIL %s actual %0d expected %0d", tag, actv, expv);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic pulse_load();
    wr(A_LD, 32'h2);
    #100;
    wr(A_LD, 32'h0);
  endtask

  task automatic measure(input int win, output int per, output int n);
    int e0;
    e0 = edges;
    #(win);
    n = edges - e0;
    per = (n >= 2) ? int'(t_last - t_prev) : 0;
  endtask

  initial begin
    logic [31:0] d;
    int per, n, prev;
    #52 rst_n = 1;
    rd(A_SEL, d); check("R1 select reset", d, 0);
    rd(A_EN, d);  check("R1 enable reset", d, 0);
    rd(A_DIV, d); check("R1 divide reset", d, 0);
    rd(A_LD, d);  check("R1 load reset", d, 0);
    measure(300, per, n); check("R1 R8 no edges after reset", n, 0);

    wr(A_SEL, 32'hFFFF_FFFF); rd(A_SEL, d); check("R2 select layout", d, 32'h8);
    wr(A_EN, 32'hFFFF_FFF7);  rd(A_EN, d);  check("R2 enable layout", d, 0);
    rd(8'h84, d); check("R2 unmapped read", d, 0);
    wr(A_SEL, 32'h0);
    wr(A_EN, 32'h8);

    prev = 6;
    for (int i = 0; i < NV; i++) begin
      wr(A_SEL, 32'(V_SEL[i]) << 3);
      wr(A_DIV, 32'(V_DIV[i]) << 16);
      pulse_load();
      #(3 * prev + 400);
      measure(4 * V_PER[i] + 100, per, n);
      check($sformatf("R3 R4 vector %0d period", i), per, V_PER[i]);
      prev = V_PER[i];
    end

    wr(A_DIV, 32'd9 << 16);
    rd(A_DIV, d); check("R5 staged readback", d, 32'd9 << 16);
    #400;
    measure(500, per, n); check("R6 no change without load", per, 112);
    pulse_load();
    #(3 * 112 + 400);
    measure(4 * 140 + 100, per, n); check("R6 R10 new ratio after load", per, 10 * T1);

    wr(A_EN, 32'h0);
    #200;
    measure(600, per, n); check("R8 gated no edges", n, 0);
    wr(A_DIV, 32'd3 << 16);
    pulse_load();
    #100;
    wr(A_EN, 32'h8);
    #(3 * 140 + 400);
    measure(4 * 140 + 100, per, n); check("R7 gated load ignored", per, 10 * T1);
    pulse_load();
    #(3 * 140 + 400);
    measure(4 * 56 + 100, per, n); check("R7 reload applies", per, 4 * T1);

    wr(A_SEL, 32'h0);
    #(3 * 56 + 400);
    measure(4 * 24 + 100, per, n); check("R3 R9 back to parent 0", per, 4 * T0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule